// File: doc/BRIEF.md
# Steerable Level-Sensitive Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt lines (32 by default) and presents them to a processor on two outputs: a normal interrupt request and a fast interrupt request. Each line passes through an enable bit and a routing bit. The enable bit lets the line through. The routing bit sends it to either the normal or the fast output. There is no acknowledge. A line stays pending while its input is high and clears once the input drops.

Software works through a small register bus with single-cycle writes and combinational reads. It can read three pending views: the unfiltered sampled lines, the enabled lines routed to the normal output, and the enabled lines routed to the fast output. The block also gives the index of the lowest-numbered pending normal request, so the service loop need not scan bits. A wake output to an idle processor follows one control bit. When the bit is set, only enabled lines can wake the processor. When it is clear, any pending line can.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset the enable register (offset 0x04), routing register (0x08) and control register (0x0C) all read zero, and irq_o and fiq_o are low. An asynchronous reset clears these registers immediately.
- R2: The raw view at offset 0x20 reads the source lines as sampled on the previous clock edge. Bus writes to offsets 0x20, 0x00 and 0x10 change no register.
- R3: An enable bit of 1 lets its source through and 0 blocks it. With every enable bit at 0, irq_o and fiq_o stay low. Setting a single bit by read-modify-write of offset 0x04 leaves the other bits unchanged.
- R4: The normal pending view at offset 0x00 equals raw AND enable AND NOT routing. irq_o is high exactly when this view is nonzero. It clears when the source deasserts.
- R5: The fast pending view at offset 0x10 equals raw AND enable AND routing. A routing bit of 1 selects the fast path. fiq_o is high exactly when this view is nonzero.
- R6: irq_idx_o gives the lowest-numbered set bit of the normal pending view, and irq_idx_vld_o is high when that view is nonzero. When the flag is low, the index is 0.
- R7: wake_o is low when cpu_idle_i is low. When control bit 0 is 1, wake_o is high only if some enabled source is pending, on either path.
- R8: When control bit 0 is 0 and cpu_idle_i is high, wake_o is high whenever any raw source is pending, whether or not it is enabled.
- R9: The enable and routing registers read back what was written. The control register keeps only bit 0, and its other bits read zero. Unmapped offsets such as 0x18 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level-sensitive source lines |
| cpu_idle_i | input | 1 | Processor is idle and waiting for an interrupt |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | NSRC | Write data |
| bus_rdata_o | output | NSRC | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to the idle processor |
| irq_idx_o | output | IDX_W | Index of the lowest pending normal source |
| irq_idx_vld_o | output | 1 | irq_idx_o is meaningful |

## Verification
The hardest case to set up is a mixed pattern. Several enabled lines must be pending at once, with some routed to the fast path, so that the lowest raw bit is not the lowest normal bit. Reaching it takes enable and routing words written over the bus ahead of a matching source pattern. The table in the bench pairs such words with source vectors whose lowest normal index sits above a lower fast-routed line. The wake cases need the control bit flipped under the same blocked source pattern, so that the only difference between the two cases is the control bit.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned REG_AW = 6;

  // Register offsets; software service code relies on these positions
  localparam logic [REG_AW-1:0] OFS_IRQ_PEND = 6'h00;
  localparam logic [REG_AW-1:0] OFS_ENABLE   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_ROUTE    = 6'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_FIQ_PEND = 6'h10;
  localparam logic [REG_AW-1:0] OFS_RAW      = 6'h20;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  input  logic [NSRC-1:0]   pend_irq_i,
  input  logic [NSRC-1:0]   pend_fiq_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic [NSRC-1:0]   raw_o,
  output logic [NSRC-1:0]   enable_o,
  output logic [NSRC-1:0]   route_o,
  output logic              ctrl_wake_o
);
  logic [NSRC-1:0] raw_q, raw_d;
  logic [NSRC-1:0] enable_q, enable_d;
  logic [NSRC-1:0] route_q, route_d;
  logic            ctrl_q, ctrl_d;
  logic            enable_en, route_en, ctrl_en;

  // write decode as clock enables
  always_comb begin
    enable_en = bus_wr_i && (bus_addr_i == OFS_ENABLE);
    route_en  = bus_wr_i && (bus_addr_i == OFS_ROUTE);
    ctrl_en   = bus_wr_i && (bus_addr_i == OFS_CTRL);
  end

  // next-state
  always_comb begin
    raw_d    = src_i;
    enable_d = enable_en ? bus_wdata_i    : enable_q;
    route_d  = route_en  ? bus_wdata_i    : route_q;
    ctrl_d   = ctrl_en   ? bus_wdata_i[0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= '0;
      enable_q <= '0;
      route_q  <= '0;
      ctrl_q   <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      enable_q <= enable_d;
      route_q  <= route_d;
      ctrl_q   <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_IRQ_PEND: bus_rdata_o = pend_irq_i;
      OFS_ENABLE:   bus_rdata_o = enable_q;
      OFS_ROUTE:    bus_rdata_o = route_q;
      OFS_CTRL:     bus_rdata_o = {{(NSRC-1){1'b0}}, ctrl_q};
      OFS_FIQ_PEND: bus_rdata_o = pend_fiq_i;
      OFS_RAW:      bus_rdata_o = raw_q;
      default:      bus_rdata_o = '0;
    endcase
  end

  assign raw_o       = raw_q;
  assign enable_o    = enable_q;
  assign route_o     = route_q;
  assign ctrl_wake_o = ctrl_q;
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route #(
  parameter int unsigned NSRC = 32
) (
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic [NSRC-1:0] route_i,
  input  logic            ctrl_wake_i,
  input  logic            cpu_idle_i,
  output logic [NSRC-1:0] pend_irq_o,
  output logic [NSRC-1:0] pend_fiq_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            wake_o
);
  logic [NSRC-1:0] live;

  always_comb begin
    live       = raw_i & enable_i;
    pend_irq_o = live & ~route_i;
    pend_fiq_o = live & route_i;
    irq_o      = |pend_irq_o;
    fiq_o      = |pend_fiq_o;
    // control bit selects whether blocked lines may wake the core
    wake_o     = cpu_idle_i && (ctrl_wake_i ? (|live) : (|raw_i));
  end
endmodule

// File: rtl/irq_steer_prio.sv
module irq_steer_prio #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              cpu_idle_i,
  input  logic              bus_wr_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic              irq_idx_vld_o
);
  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic [NSRC-1:0] raw_q, enable_q, route_q;
  logic            ctrl_wake_q;
  logic [NSRC-1:0] pend_irq, pend_fiq;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  irq_steer_regs #(.NSRC(NSRC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .src_i       (src_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pend_irq_i  (pend_irq),
    .pend_fiq_i  (pend_fiq),
    .bus_rdata_o (bus_rdata_o),
    .raw_o       (raw_q),
    .enable_o    (enable_q),
    .route_o     (route_q),
    .ctrl_wake_o (ctrl_wake_q)
  );

  irq_steer_route #(.NSRC(NSRC)) u_route (
    .raw_i       (raw_q),
    .enable_i    (enable_q),
    .route_i     (route_q),
    .ctrl_wake_i (ctrl_wake_q),
    .cpu_idle_i  (cpu_idle_i),
    .pend_irq_o  (pend_irq),
    .pend_fiq_o  (pend_fiq),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .wake_o      (wake_o)
  );

  irq_steer_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
    .vec_i (pend_irq),
    .idx_o (irq_idx_o),
    .vld_o (irq_idx_vld_o)
  );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src,
  input logic [NSRC-1:0]   raw,
  input logic [NSRC-1:0]   mask,
  input logic [NSRC-1:0]   level,
  input logic              ctrl,
  input logic              idle,
  input logic              irq,
  input logic              fiq,
  input logic              wake,
  input logic [IDX_W-1:0]  idx,
  input logic              vld,
  input logic              wr,
  input logic [REG_AW-1:0] addr,
  input logic [NSRC-1:0]   wdata
);
  logic [NSRC-1:0] below;
  assign below = (NSRC'(1) << idx) - NSRC'(1);

  a_r2_raw_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw == $past(src));
  a_r3_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (!irq && !fiq));
  a_r4_irq_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq == vld);
  a_r6_idx_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (raw[idx] && mask[idx] && !level[idx]));
  a_r6_idx_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((raw & mask & ~level & below) == '0));
  a_r7_no_wake_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !wake);
  a_r7_blocked_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl && ((raw & mask) == '0)) |-> !wake);
  a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_ENABLE) |=> mask == $past(wdata));
endmodule

bind irq_steer_ctrl irq_steer_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .src   (src_i),
  .raw   (raw_q),
  .mask  (enable_q),
  .level (route_q),
  .ctrl  (ctrl_wake_q),
  .idle  (cpu_idle_i),
  .irq   (irq_o),
  .fiq   (fiq_o),
  .wake  (wake_o),
  .idx   (irq_idx_o),
  .vld   (irq_idx_vld_o),
  .wr    (bus_wr_i),
  .addr  (bus_addr_i),
  .wdata (bus_wdata_i)
);

// File: tb/test_irq_steer_ctrl.sv
module test_irq_steer_ctrl;
  localparam int NSRC = 32;
  localparam int VW   = 32 * 3 + 2 + 4 + 5;
  localparam int NV   = 7;

  // {src, enable, route, ctrl, idle, exp irq, fiq, wake, vld, exp idx}
  localparam logic [VW-1:0] TBL [NV] = '{
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 4'b1001, 5'd0},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 4'b1011, 5'd31},
    {32'h0000_0F00, 32'h0000_0C00, 32'h0000_0400, 1'b1, 1'b1, 4'b1111, 5'd11},
    {32'h0000_00F0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 4'b0000, 5'd0},
    {32'h0000_00F0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 4'b0010, 5'd0},
    {32'hFFFF_FFFF, 32'hFFFF_F000, 32'hFFFF_0000, 1'b1, 1'b1, 4'b1111, 5'd12},
    {32'h0000_0006, 32'h0000_0004, 32'h0000_0004, 1'b0, 1'b0, 4'b0100, 5'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src;
  logic            idle;
  logic            wr;
  logic [5:0]      addr;
  logic [NSRC-1:0] wdata;
  logic [NSRC-1:0] rdata;
  logic            irq, fiq, wake, vld;
  logic [4:0]      idx;
  int              total = 0;
  int              bad   = 0;

  always #5 clk = ~clk;

  irq_steer_ctrl #(.NSRC(NSRC)) i_irq_steer_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cpu_idle_i(idle),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake),
    .irq_idx_o(idx), .irq_idx_vld_o(vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; src = '0; idle = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(6'h04, rv); check("R1 enable", rv, 0);
    bus_read(6'h08, rv); check("R1 route", rv, 0);
    bus_read(6'h0C, rv); check("R1 ctrl", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 fiq", {31'b0, fiq}, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = TBL[k];
      bus_write(6'h04, v[VW-33 -: 32]);
      bus_write(6'h08, v[VW-65 -: 32]);
      bus_write(6'h0C, {31'b0, v[10]});
      src  = v[VW-1 -: 32];
      idle = v[9];
      @(negedge clk);
      check($sformatf("R4 irq v%0d", k),  {31'b0, irq},  {31'b0, v[8]});
      check($sformatf("R5 fiq v%0d", k),  {31'b0, fiq},  {31'b0, v[7]});
      check($sformatf("R7 R8 wake v%0d", k), {31'b0, wake}, {31'b0, v[6]});
      check($sformatf("R6 vld v%0d", k),  {31'b0, vld},  {31'b0, v[5]});
      check($sformatf("R6 idx v%0d", k),  {27'b0, idx},  {27'b0, v[4:0]});
    end

    // R4 R5 pending views: src 0xF00, enable 0xC00, route 0x400
    bus_write(6'h04, 32'h0000_0C00);
    bus_write(6'h08, 32'h0000_0400);
    src = 32'h0000_0F00;
    @(negedge clk);
    bus_read(6'h00, rv); check("R4 irq view", rv, 32'h0000_0800);
    bus_read(6'h10, rv); check("R5 fiq view", rv, 32'h0000_0400);

    // R4 deassert clears without acknowledge
    src = '0;
    @(negedge clk);
    check("R4 clear irq", {31'b0, irq}, 0);
    bus_read(6'h00, rv); check("R4 clear view", rv, 0);

    // R2 raw view and read-only offsets
    src = 32'hA5A5_0003;
    @(negedge clk);
    bus_read(6'h20, rv); check("R2 raw", rv, 32'hA5A5_0003);
    bus_write(6'h20, 32'h0);
    bus_write(6'h00, 32'hFFFF_FFFF);
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_read(6'h20, rv); check("R2 raw after write", rv, 32'hA5A5_0003);
    bus_read(6'h04, rv); check("R2 enable untouched", rv, 32'h0000_0C00);
    bus_read(6'h08, rv); check("R2 route untouched", rv, 32'h0000_0400);

    // R9 control width, unmapped offset, readback
    bus_write(6'h0C, 32'hFFFF_FFFF);
    bus_read(6'h0C, rv); check("R9 ctrl bit0 only", rv, 1);
    bus_read(6'h18, rv); check("R9 unmapped", rv, 0);
    bus_write(6'h08, 32'h1234_5678);
    bus_read(6'h08, rv); check("R9 route readback", rv, 32'h1234_5678);

    // R3 read-modify-write of one enable bit
    bus_write(6'h04, 32'h8000_0001);
    bus_read(6'h04, rv);
    bus_write(6'h04, rv | 32'h20);
    bus_read(6'h04, rv); check("R3 rmw", rv, 32'h8000_0021);
    bus_write(6'h04, 32'h0);
    src = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R3 blocked irq", {31'b0, irq}, 0);
    check("R3 blocked fiq", {31'b0, fiq}, 0);

    // R1 asynchronous reset clears registers at once
    bus_write(6'h04, 32'hFFFF_FFFF);
    rst_n = 1'b0;
    #1;
    bus_read(6'h04, rv); check("R1 async clear", rv, 0);
    check("R1 async irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule